// File: doc/BRIEF.md
# Clocked Synchronous Serial Port

This block is an 8-bit serial port that moves data in clocked synchronous frames. A transmit path and a receive path share one serial clock, which the block drives itself. Software reaches it through a small register interface. The interface holds two enable bits, a transmit byte register, a receive byte register and four status flags: transmit empty, transmit done, receive full and overrun.

Each frame is eight bits, least significant bit first. The block shifts transmit data out on the falling serial clock edge and samples receive data on the rising edge. When a received frame lands in the receive register, the receive-full flag sets and the interrupt output goes high. A DMA engine that answers the interrupt can pulse the DMA read strobe. That strobe returns the received byte and clears the flag without any software write.

If a second frame completes while the receive-full flag is still set, the overrun flag sets and the new frame is dropped. Reception then stops, and the serial clock halts for receiving, until software clears the overrun flag. To run full duplex, software enables both paths in a single control write.

Top module: `sync_serial_port`

## Requirements
- R1: After reset the status reads 0x03: transmit empty (bit 0) = 1, transmit done (bit 1) = 1, receive full (bit 2) = 0, overrun (bit 3) = 0. The control register reads 0, the serial clock and the transmit line are high, and the interrupt is low.
- R2: The register map is as follows. Address 0 is control: bit 0 enables transmit and bit 1 enables receive. Address 1 is status, laid out as in R1; writing 0 to bit 2 or bit 3 clears that flag, and writing 1 leaves it alone. Address 2 holds transmit data. Address 3 reads the receive data. A read presents its data on rdata one clock after rd_en.
- R3: The serial clock idles high. In a frame it gives eight periods, each DIV_HALF clocks low followed by DIV_HALF clocks high, for 8*DIV_HALF low clocks in total. It runs only while a transmit frame is pending or active, or while receive is enabled and no overrun is pending.
- R4: Transmit data goes out least significant bit first. txd_o changes only with a falling serial clock and holds at every rising edge. It idles high.
- R5: A write to the transmit register clears transmit empty and transmit done. Transmit empty sets again when the byte moves into the shifter. Transmit done sets at frame end only if no new byte is waiting. A byte written while a frame is active follows that frame directly, and transmit done stays 0 between the two frames.
- R6: Receive data is sampled on rising serial clock edges, least significant bit first. After the eighth sample the byte sits in the receive register, receive full is 1 and irq_rx_full is high.
- R7: A dma_rd pulse returns the receive byte on rdata one clock later and clears receive full, which lowers irq_rx_full.
- R8: A frame that completes while receive full is 1 sets overrun. The receive register keeps the earlier byte. No serial clock runs for reception until overrun is cleared, and the next frame after that is received normally.
- R9: Clearing receive enable during a receive-only frame stops the serial clock and restarts the bit count, and leaves all status flags and the receive register unchanged.
- R10: With both enables set in one write, each frame shifts a transmit byte out and takes a receive byte in on the same serial clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| dma_rd | input | 1 | DMA read of the receive register; clears receive full |
| irq_rx_full | output | 1 | Receive-full interrupt request |
| sclk_o | output | 1 | Serial clock output |
| txd_o | output | 1 | Serial transmit data |
| rxd_i | input | 1 | Serial receive data |

## Verification
The assertions rely on these assumptions about the inputs:
- rxd_i settles well away from a rising serial clock edge.
- A status write never lands in the same clock as the eighth receive sample.
- Mode changes follow the enable procedure.

To keep within these, the bench's serial partner updates rxd_i only on the falling serial clock. Flags are cleared within a few clocks of the interrupt, far ahead of the next frame's last bit. Overrun is only provoked on purpose, by leaving receive full set over a whole frame.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_TXD  = 2'd2,
    REG_RXD  = 2'd3
  } reg_addr_e;

  localparam int CT_TXEN = 0;
  localparam int CT_RXEN = 1;

  localparam int ST_TDE  = 0;
  localparam int ST_TEND = 1;
  localparam int ST_RDF  = 2;
  localparam int ST_OVR  = 3;
endpackage

// File: rtl/ssp_seq.sv
module ssp_seq #(
  parameter int DATA_W   = 8,
  parameter int DIV_HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic abort,
  output logic busy,
  output logic sclk,
  output logic first_fall,
  output logic next_fall,
  output logic rise_stb,
  output logic last_rise,
  output logic end_stb
);
  localparam int CNT_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] DIV_LAST = CNT_W'(DIV_HALF - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

  logic             busy_q, sclk_q;
  logic [CNT_W-1:0] div_q;
  logic [BIT_W-1:0] bit_q;
  logic             tick, last_bit;

  assign tick       = busy_q && (div_q == DIV_LAST);
  assign last_bit   = (bit_q == BIT_LAST);
  assign first_fall = !busy_q && start;
  assign rise_stb   = tick && !sclk_q;
  assign next_fall  = tick && sclk_q && !last_bit;
  assign end_stb    = tick && sclk_q && last_bit;
  assign last_rise  = rise_stb && last_bit;
  assign busy       = busy_q;
  assign sclk       = sclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b1;
      div_q  <= '0;
      bit_q  <= '0;
    end else if (abort && busy_q) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b1;
      div_q  <= '0;
      bit_q  <= '0;
    end else if (first_fall) begin
      busy_q <= 1'b1;
      sclk_q <= 1'b0;
      div_q  <= '0;
      bit_q  <= '0;
    end else if (busy_q) begin
      if (tick) begin
        div_q <= '0;
        if (!sclk_q) begin
          sclk_q <= 1'b1;
        end else if (last_bit) begin
          busy_q <= 1'b0;
          bit_q  <= '0;
        end else begin
          sclk_q <= 1'b0;
          bit_q  <= bit_q + 1'b1;
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ssp_tx.sv
module ssp_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] data_in,
  input  logic              shift_en,
  input  logic              idle,
  output logic              txd
);
  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= '0;
      txd  <= 1'b1;
    end else if (load) begin
      sh_q <= data_in;
      txd  <= data_in[0];
    end else if (shift_en) begin
      sh_q <= sh_q >> 1;
      txd  <= sh_q[1];
    end else if (idle) begin
      txd  <= 1'b1;
    end
  end
endmodule

// File: rtl/ssp_rx.sv
module ssp_rx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              sample,
  input  logic              rxd,
  output logic [DATA_W-1:0] word
);
  logic [DATA_W-1:0] sh_q;

  assign word = {rxd, sh_q[DATA_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      sh_q <= '0;
    end else if (sample) begin
      sh_q <= word;
    end
  end
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
  import ssp_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int DIV_HALF = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              dma_rd,
  output logic              irq_rx_full,
  output logic              sclk_o,
  output logic              txd_o,
  input  logic              rxd_i
);
  localparam int PAD_C = DATA_W - 2;
  localparam int PAD_S = DATA_W - 4;

  logic              tx_en_q, rx_en_q;
  logic [DATA_W-1:0] tdr_q, rdr_q;
  logic              tde_q, tend_q, rdf_q, ovr_q;
  logic              tx_act_q, rx_act_q;

  logic wr_ctrl, wr_stat, wr_txd;
  logic tx_go, rx_go, start, abort, rx_live, done_rx;
  logic busy, first_fall, next_fall, rise_stb, last_rise, end_stb;
  logic [DATA_W-1:0] rx_word;

  assign wr_ctrl = wr_en && (addr == REG_CTRL);
  assign wr_stat = wr_en && (addr == REG_STAT);
  assign wr_txd  = wr_en && (addr == REG_TXD);

  assign tx_go   = tx_en_q && !tde_q;
  assign rx_go   = rx_en_q && !ovr_q;
  assign start   = tx_go || rx_go;
  assign abort   = busy && !tx_act_q && !rx_en_q;
  assign rx_live = rx_act_q && rx_en_q;
  assign done_rx = last_rise && rx_live;

  ssp_seq #(.DATA_W(DATA_W), .DIV_HALF(DIV_HALF)) u_seq (
    .clk(clk), .rst(rst), .start(start), .abort(abort),
    .busy(busy), .sclk(sclk_o), .first_fall(first_fall),
    .next_fall(next_fall), .rise_stb(rise_stb),
    .last_rise(last_rise), .end_stb(end_stb)
  );

  ssp_tx #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst(rst),
    .load(first_fall && tx_go), .data_in(tdr_q),
    .shift_en(next_fall && tx_act_q), .idle(end_stb),
    .txd(txd_o)
  );

  ssp_rx #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst(rst), .clear(first_fall || abort),
    .sample(rise_stb && rx_live), .rxd(rxd_i), .word(rx_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_en_q  <= 1'b0;
      rx_en_q  <= 1'b0;
      tdr_q    <= '0;
      rdr_q    <= '0;
      tde_q    <= 1'b1;
      tend_q   <= 1'b1;
      rdf_q    <= 1'b0;
      ovr_q    <= 1'b0;
      tx_act_q <= 1'b0;
      rx_act_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        tx_en_q <= wdata[CT_TXEN];
        rx_en_q <= wdata[CT_RXEN];
      end
      if (first_fall) begin
        tx_act_q <= tx_go;
        rx_act_q <= rx_go;
        if (tx_go) tde_q <= 1'b1;
      end
      if (end_stb || abort) begin
        tx_act_q <= 1'b0;
        rx_act_q <= 1'b0;
      end
      if (end_stb && tx_act_q && tde_q && !wr_txd) tend_q <= 1'b1;
      if (!rx_en_q) rx_act_q <= 1'b0;
      if (wr_txd) begin
        tdr_q  <= wdata;
        tde_q  <= 1'b0;
        tend_q <= 1'b0;
      end
      if (wr_stat && !wdata[ST_RDF]) rdf_q <= 1'b0;
      if (wr_stat && !wdata[ST_OVR]) ovr_q <= 1'b0;
      if (dma_rd) rdf_q <= 1'b0;
      if (done_rx) begin
        if (rdf_q) begin
          ovr_q <= 1'b1;
        end else begin
          rdr_q <= rx_word;
          rdf_q <= 1'b1;
        end
      end
    end
  end

  assign irq_rx_full = rdf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (dma_rd) begin
      rdata <= rdr_q;
    end else if (rd_en) begin
      case (addr)
        REG_CTRL: rdata <= {{PAD_C{1'b0}}, rx_en_q, tx_en_q};
        REG_STAT: rdata <= {{PAD_S{1'b0}}, ovr_q, rdf_q, tend_q, tde_q};
        REG_TXD:  rdata <= tdr_q;
        default:  rdata <= rdr_q;
      endcase
    end
  end

  // R3
  sclk_src_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sclk_o) |-> (tx_act_q || rx_act_q));

  // R4
  txd_stable_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk_o) |-> $stable(txd_o));

  // R5
  tend_tde_chk: assert property (@(posedge clk) disable iff (rst)
    tend_q |-> tde_q);

  // R6
  rdf_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rdf_q) |-> $past(done_rx));

  // R7
  dma_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (dma_rd && !done_rx) |=> !rdf_q);

  // R8
  ovr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ovr_q |=> $stable(rdr_q));
endmodule

// File: tb/tb_sync_serial_port.sv
module tb_sync_serial_port;
  localparam int DW = 8;
  localparam int DH = 2;
  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_TXD = 2'd2, A_RXD = 2'd3;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0, dma_rd = 1'b0, rxd_i = 1'b1;
  logic [1:0] addr = 2'd0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic irq_rx_full, sclk_o, txd_o;

  int n_vec = 0, n_bad = 0;
  int slv_idx = 0, slv_frames = 0, falls = 0, low_cyc = 0;
  logic [7:0] slv_byte, slv_cap, slv_last_cap;

  sync_serial_port #(.DATA_W(DW), .DIV_HALF(DH)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .dma_rd(dma_rd), .irq_rx_full(irq_rx_full),
    .sclk_o(sclk_o), .txd_o(txd_o), .rxd_i(rxd_i)
  );

  always #4 clk = ~clk;

  function automatic logic [7:0] pat(input int n);
    pat = n[7:0] ^ 8'h5A;
  endfunction

  function automatic logic [7:0] tpat(input int n);
    tpat = n[7:0] * 8'd29 + 8'd7;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic dma(output logic [7:0] d);
    dma_rd = 1'b1;
    @(negedge clk);
    dma_rd = 1'b0;
    d = rdata;
  endtask

  task automatic slave_reset(input int n);
    slv_idx = 0;
    slv_frames = n;
    slv_byte = pat(n);
  endtask

  task automatic wait_irq();
    wait (irq_rx_full);
    @(negedge clk);
  endtask

  always @(negedge sclk_o) if (!rst) begin
    falls++;
    rxd_i = slv_byte[slv_idx];
  end

  always @(posedge sclk_o) if (!rst) begin
    slv_cap[slv_idx] = txd_o;
    if (slv_idx == 7) begin
      slv_last_cap = slv_cap;
      slv_frames++;
      slv_idx = 0;
      slv_byte = pat(slv_frames);
    end else begin
      slv_idx++;
    end
  end

  always @(posedge clk) if (!rst && !sclk_o) low_cyc++;

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R3 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] s, d;
    int f0;
    slave_reset(0);
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(A_STAT, s); chk("R1 status", s, 8'h03);
    rd(A_CTRL, s); chk("R1 control", s, 8'h00);
    chk("R1 sclk", sclk_o, 1); chk("R1 txd", txd_o, 1); chk("R1 irq", irq_rx_full, 0);

    // R3 no serial clock while idle
    f0 = falls;
    repeat (40) @(negedge clk);
    chk("R3 idle clock", falls - f0, 0);

    // R4 R5 exhaustive transmit sweep
    wr(A_CTRL, 8'h01);
    for (int b = 0; b < 256; b++) begin
      low_cyc = 0;
      wr(A_TXD, b[7:0]);
      rd(A_STAT, s);
      chk("R5 flags after write", s[1:0], 2'b00);
      do rd(A_STAT, s); while (!s[1]);
      chk("R4 tx byte", slv_last_cap, b[7:0]);
      chk("R5 tde at end", s[0], 1);
      if (b == 0) chk("R3 low clocks", low_cyc, 8 * DH);
    end
    // R5 back-to-back bytes
    f0 = slv_frames;
    wr(A_TXD, 8'hC3);
    wr(A_TXD, 8'h3C);
    rd(A_STAT, s);
    chk("R5 tend held", s[1], 0);
    do rd(A_STAT, s); while (!s[1]);
    chk("R5 two frames", slv_frames - f0, 2);
    chk("R5 second byte", slv_last_cap, 8'h3C);
    wr(A_CTRL, 8'h00);
    repeat (10) @(negedge clk);

    // R6 R7 R2 exhaustive receive sweep
    slave_reset(0);
    wr(A_CTRL, 8'h02);
    for (int k = 0; k < 256; k++) begin
      wait_irq();
      chk("R6 irq", irq_rx_full, 1);
      if (k % 2 == 0) begin
        dma(d);
        chk("R7 dma data", d, pat(k));
        chk("R7 irq cleared", irq_rx_full, 0);
      end else begin
        rd(A_RXD, d);
        chk("R6 rx data", d, pat(k));
        wr(A_STAT, 8'h08);
        rd(A_STAT, s);
        chk("R2 clear by zero", s[3:2], 2'b00);
      end
    end
    wr(A_CTRL, 8'h00);
    repeat (10) @(negedge clk);

    // R8 overrun
    slave_reset(0);
    wr(A_CTRL, 8'h02);
    wait_irq();
    do rd(A_STAT, s); while (!s[3]);
    chk("R8 rdf kept", s[2], 1);
    rd(A_RXD, d);
    chk("R8 old byte", d, pat(0));
    f0 = falls;
    repeat (100) @(negedge clk);
    chk("R8 clock frozen", falls - f0, 0);
    chk("R8 frames", slv_frames, 2);
    wr(A_STAT, 8'h00);
    wait_irq();
    dma(d);
    chk("R8 resume byte", d, pat(2));
    wr(A_CTRL, 8'h00);
    repeat (10) @(negedge clk);

    // R9 receive disable mid-frame
    slave_reset(0);
    wr(A_CTRL, 8'h02);
    wait_irq();
    wait (slv_idx == 4);
    @(negedge clk);
    wr(A_CTRL, 8'h00);
    f0 = falls;
    repeat (20) @(negedge clk);
    chk("R9 clock stopped", falls - f0, 0);
    chk("R9 sclk high", sclk_o, 1);
    rd(A_STAT, s);
    chk("R9 flags kept", s, 8'h07);
    rd(A_RXD, d);
    chk("R9 rdr kept", d, pat(0));
    wr(A_STAT, 8'h00);
    slave_reset(9);
    wr(A_CTRL, 8'h02);
    wait_irq();
    dma(d);
    chk("R9 fresh frame", d, pat(9));
    wr(A_CTRL, 8'h00);
    repeat (10) @(negedge clk);

    // R10 full duplex
    slave_reset(0);
    wr(A_TXD, tpat(0));
    wr(A_CTRL, 8'h03);
    for (int n = 0; n < 12; n++) begin
      if (n > 0 && n < 12) begin
        // frame n already loaded; nothing to do
      end
      if (n < 11) wr(A_TXD, tpat(n + 1));
      wait_irq();
      chk("R10 tx byte", slv_last_cap, tpat(n));
      dma(d);
      chk("R10 rx byte", d, pat(n));
      repeat (DH + 3) @(negedge clk);
    end
    do rd(A_STAT, s); while (!s[1]);
    chk("R10 tend", s[1:0], 2'b11);
    wr(A_CTRL, 8'h00);
    repeat (10) @(negedge clk);

    finish_run();
  end
endmodule